// File: doc/BRIEF.md
# Memory Read Protection Filter

This block sits between a processor core's data-read path, its host-port path and the on-chip memories, and applies a read-protection policy when a security strap is set. A data read that lands in the on-chip ROM window is granted only when the instruction that issued it was itself fetched from ROM. Otherwise the memory is not strobed and the all-ones fill word is returned in the cycle a real read would have answered. Reads of on-chip RAM and of any address outside the ROM window are never filtered.

The host port may write anywhere. It may read only inside one fixed window; a read outside it is answered with the fill word and a one-cycle violation pulse. The block also holds the microcomputer/microprocessor mode bit. With security on, reset forces that bit to microcomputer mode, and software may change it later. The block blocks the debug-emulation enable while security is on. When the strap is clear, every request passes unchanged and the emulation enable follows its request input.

The core supplies the fetch origin as a 2-bit tag whenever an instruction advances into execute. The block registers the tag, so each data read is judged by the origin of the instruction already in execute.

Top module: `secure_access_filter`

## Requirements
- R1: With `sec_en`=1 during reset, `mode_bit` is 0 after reset whatever `ext_mode_pin` is. `dr_valid`, `hp_rvalid` and `hp_viol` are 0 after reset.
- R2: With `sec_en`=0 during reset, `mode_bit` takes the value of `ext_mode_pin` after reset.
- R3: Out of reset, `mode_wr`=1 loads `mode_wdata` into `mode_bit` at the next clock edge.
- R4: Origin codes are 0 = ROM, 1 = RAM, 2 = external, and 3 is treated as non-ROM. Suppose security is on and the registered origin is ROM. A data read at 0xC000..0xFFFF then raises `dm_rd` in the same cycle, and `dr_data` returns `dm_rdata` with `dr_valid`=1 one cycle later.
- R5: Suppose security is on and the registered origin is RAM or external. A data read at 0xC000..0xFFFF then leaves `dm_rd` low, and one cycle later `dr_valid`=1 with `dr_data`=0xFFFF.
- R6: A data read below 0xC000 is strobed and answered with memory data for every origin.
- R7: The origin used for a read is the tag captured at the last `ex_adv` strictly before the read's cycle. An `ex_adv` in the read's own cycle does not affect that read.
- R8: Host writes raise `hm_wr` in the same cycle at any address, in both security states.
- R9: Host reads at 0x4000..0x5FFF inclusive raise `hm_rd`, and one cycle later `hp_rvalid`=1 with `hp_rdata`=`hm_rdata` and `hp_viol`=0.
- R10: Suppose security is on. A host read outside 0x4000..0x5FFF leaves `hm_rd` low, and one cycle later gives `hp_rvalid`=1, `hp_rdata`=0xFFFF and a one-cycle `hp_viol`=1.
- R11: With security off, ROM reads from any origin and host reads at any address are strobed and return memory data, and `hp_viol` stays 0.
- R12: `emu_en` equals `emu_req` when security is off and is 0 when security is on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sec_en | input | 1 | Security strap |
| ext_mode_pin | input | 1 | External mode pin level |
| mode_wr | input | 1 | Software write of the mode bit |
| mode_wdata | input | 1 | Value written to the mode bit |
| mode_bit | output | 1 | Current mode bit (0 = microcomputer) |
| emu_req | input | 1 | External debug-emulation enable request |
| emu_en | output | 1 | Gated emulation enable |
| ex_adv | input | 1 | Instruction advances into execute |
| ex_origin | input | 2 | Fetch origin of that instruction |
| dr_req | input | 1 | Data-read request |
| dr_addr | input | 16 | Data-read address |
| dm_rd | output | 1 | Read strobe to memory |
| dm_addr | output | 16 | Address to memory |
| dm_rdata | input | 16 | Memory read data, one cycle after the strobe |
| dr_valid | output | 1 | Data-read response valid |
| dr_data | output | 16 | Data-read response |
| hp_rd | input | 1 | Host read request |
| hp_wr | input | 1 | Host write request |
| hp_addr | input | 16 | Host address |
| hp_wdata | input | 16 | Host write data |
| hm_rd | output | 1 | Host read strobe to memory |
| hm_wr | output | 1 | Host write strobe to memory |
| hm_addr | output | 16 | Host address to memory |
| hm_wdata | output | 16 | Host write data to memory |
| hm_rdata | input | 16 | Memory data for host reads |
| hp_rvalid | output | 1 | Host read response valid |
| hp_rdata | output | 16 | Host read response |
| hp_viol | output | 1 | One-cycle blocked host-read flag |

## Verification
ROM-window reads are issued under each of the three origin tags, with security on and then off. This separates origin-based blocking from plain address decoding. One read is issued in the same cycle as an origin change, which shows whether the registered tag or the live tag is used. Host reads are placed on both edges of the permitted window and one word past each edge. Host writes are made outside the window, which exposes off-by-one window limits and any leak of the read limit onto writes. The mode bit is reset under both strap values with the pin high.

// File: rtl/saf_pkg.sv
// Shared types for the memory read protection filter.
// Assumes the core encodes the fetch origin in two bits.
package saf_pkg;
    typedef enum logic [1:0] {
        ORG_ROM = 2'd0,
        ORG_RAM = 2'd1,
        ORG_EXT = 2'd2,
        ORG_BAD = 2'd3
    } origin_t;
endpackage

// File: rtl/saf_mode_ctl.sv
// Mode bit holder and emulation gate.
// With security on, reset forces microcomputer mode (0); otherwise reset
// samples the external pin. Software writes take effect at the next edge.
module saf_mode_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic sec_en,
    input  logic ext_mode_pin,
    input  logic mode_wr,
    input  logic mode_wdata,
    input  logic emu_req,
    output logic mode_bit,
    output logic emu_en
);
    logic mode_q;

    // Purpose: hold the mode bit, forced or sampled at reset.
    always_ff @(posedge clk) begin
        if (!rst_n)       mode_q <= sec_en ? 1'b0 : ext_mode_pin;
        else if (mode_wr) mode_q <= mode_wdata;
    end

    // Purpose: block debug emulation while security is on.
    always_comb emu_en = emu_req & ~sec_en;

    assign mode_bit = mode_q;

    // R1: secure reset always leaves microcomputer mode
    a_r1_forced_mode: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!rst_n) && $past(sec_en)) |-> !mode_bit);

    // R3: a software write is visible at the next edge
    a_r3_mode_write: assert property (@(posedge clk) disable iff (!rst_n)
        mode_wr |=> (mode_bit == $past(mode_wdata)));

    // R12: emulation never enabled under security
    always_comb begin
        if (rst_n) a_r12_emu_gate: assert (!(emu_en && sec_en));
    end
endmodule

// File: rtl/saf_origin_reg.sv
// Holds the fetch origin of the instruction now in execute.
// Assumes ex_adv pulses once per instruction entering execute. Reset value is
// ROM because execution restarts in ROM in microcomputer mode.
module saf_origin_reg
    import saf_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    ex_adv,
    input  origin_t ex_origin,
    output origin_t cur_org
);
    origin_t org_q;

    // Purpose: capture the origin tag with the advancing instruction.
    always_ff @(posedge clk) begin
        if (!rst_n)      org_q <= ORG_ROM;
        else if (ex_adv) org_q <= ex_origin;
    end

    assign cur_org = org_q;

    // R7: the tag only changes on an advance
    a_r7_tag_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !ex_adv |=> $stable(cur_org));
endmodule

// File: rtl/saf_data_gate.sv
// Data-read filter for the ROM window.
// Assumes memory returns data one cycle after the strobe. Blocked reads are
// not strobed and answer with FILL on the same one-cycle timing.
module saf_data_gate
    import saf_pkg::*;
#(
    parameter int              AW     = 16,
    parameter int              DW     = 16,
    parameter logic [AW-1:0]   ROM_LO = 16'hC000,
    parameter logic [AW-1:0]   ROM_HI = 16'hFFFF,
    parameter logic [DW-1:0]   FILL   = 16'hFFFF
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sec_en,
    input  origin_t       cur_org,
    input  logic          dr_req,
    input  logic [AW-1:0] dr_addr,
    output logic          dm_rd,
    output logic [AW-1:0] dm_addr,
    input  logic [DW-1:0] dm_rdata,
    output logic          dr_valid,
    output logic [DW-1:0] dr_data
);
    localparam logic [AW:0] LO_X = {1'b0, ROM_LO};
    localparam logic [AW:0] HI_X = {1'b0, ROM_HI};

    logic rom_hit, blocked, valid_q, blk_q;

    // Purpose: decide whether this read may reach the ROM.
    always_comb begin
        rom_hit = ({1'b0, dr_addr} >= LO_X) && ({1'b0, dr_addr} <= HI_X);
        blocked = sec_en && rom_hit && (cur_org != ORG_ROM);
        dm_rd   = dr_req && !blocked;
        dm_addr = dr_addr;
    end

    // Purpose: track response timing and substitution.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            blk_q   <= 1'b0;
        end else begin
            valid_q <= dr_req;
            blk_q   <= dr_req && blocked;
        end
    end

    // Purpose: return memory data or the fill word.
    always_comb begin
        dr_valid = valid_q;
        if (blk_q)        dr_data = FILL;
        else if (valid_q) dr_data = dm_rdata;
        else              dr_data = '0;
    end

    // R5: an unstrobed request answers with fill next cycle
    a_r5_fill_next: assert property (@(posedge clk) disable iff (!rst_n)
        (dr_req && !dm_rd) |=> (dr_valid && dr_data == FILL));

    // R4: every response follows a request one cycle before
    a_r4_latency: assert property (@(posedge clk) disable iff (!rst_n)
        dr_valid |-> $past(dr_req));

    // R6: reads outside the ROM window are always strobed
    a_r6_ram_open: assert property (@(posedge clk) disable iff (!rst_n)
        (dr_req && ({1'b0, dr_addr} < LO_X)) |-> dm_rd);
endmodule

// File: rtl/saf_host_gate.sv
// Host-port filter: writes pass, reads limited to one window under security.
// Assumes a read and a write are never requested in the same cycle.
module saf_host_gate #(
    parameter int            AW    = 16,
    parameter int            DW    = 16,
    parameter logic [AW-1:0] WIN_LO = 16'h4000,
    parameter logic [AW-1:0] WIN_HI = 16'h5FFF,
    parameter logic [DW-1:0] FILL   = 16'hFFFF
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sec_en,
    input  logic          hp_rd,
    input  logic          hp_wr,
    input  logic [AW-1:0] hp_addr,
    input  logic [DW-1:0] hp_wdata,
    output logic          hm_rd,
    output logic          hm_wr,
    output logic [AW-1:0] hm_addr,
    output logic [DW-1:0] hm_wdata,
    input  logic [DW-1:0] hm_rdata,
    output logic          hp_rvalid,
    output logic [DW-1:0] hp_rdata,
    output logic          hp_viol
);
    localparam logic [AW:0] LO_X = {1'b0, WIN_LO};
    localparam logic [AW:0] HI_X = {1'b0, WIN_HI};

    logic in_win, hblock, rv_q, hb_q;

    // Purpose: check the read window and drive memory strobes.
    always_comb begin
        in_win   = ({1'b0, hp_addr} >= LO_X) && ({1'b0, hp_addr} <= HI_X);
        hblock   = sec_en && hp_rd && !in_win;
        hm_rd    = hp_rd && !hblock;
        hm_wr    = hp_wr;
        hm_addr  = hp_addr;
        hm_wdata = hp_wdata;
    end

    // Purpose: register response valid and violation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rv_q <= 1'b0;
            hb_q <= 1'b0;
        end else begin
            rv_q <= hp_rd;
            hb_q <= hblock;
        end
    end

    // Purpose: form the host response.
    always_comb begin
        hp_rvalid = rv_q;
        hp_viol   = hb_q;
        if (hb_q)      hp_rdata = FILL;
        else if (rv_q) hp_rdata = hm_rdata;
        else           hp_rdata = '0;
    end

    // R10: a violation follows an unstrobed read
    a_r10_viol_cause: assert property (@(posedge clk) disable iff (!rst_n)
        hp_viol |-> $past(hp_rd && !hm_rd));

    // R9: a strobed read under security lies inside the window
    a_r9_window: assert property (@(posedge clk) disable iff (!rst_n)
        (hm_rd && sec_en) |-> (({1'b0, hm_addr} >= LO_X) && ({1'b0, hm_addr} <= HI_X)));

    // R11: no violation when security was off
    a_r11_open: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!sec_en) |-> !hp_viol);
endmodule

// File: rtl/secure_access_filter.sv
// Top of the memory read protection filter. Wires the mode control, the
// origin register, the data-read gate and the host gate.
// Assumes sec_en is static while out of reset.
module secure_access_filter
    import saf_pkg::*;
#(
    parameter int             AW     = 16,
    parameter int             DW     = 16,
    parameter logic [AW-1:0]  ROM_LO = 16'hC000,
    parameter logic [AW-1:0]  ROM_HI = 16'hFFFF,
    parameter logic [AW-1:0]  WIN_LO = 16'h4000,
    parameter logic [AW-1:0]  WIN_HI = 16'h5FFF,
    parameter logic [DW-1:0]  FILL   = 16'hFFFF
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sec_en,
    input  logic          ext_mode_pin,
    input  logic          mode_wr,
    input  logic          mode_wdata,
    output logic          mode_bit,
    input  logic          emu_req,
    output logic          emu_en,
    input  logic          ex_adv,
    input  logic [1:0]    ex_origin,
    input  logic          dr_req,
    input  logic [AW-1:0] dr_addr,
    output logic          dm_rd,
    output logic [AW-1:0] dm_addr,
    input  logic [DW-1:0] dm_rdata,
    output logic          dr_valid,
    output logic [DW-1:0] dr_data,
    input  logic          hp_rd,
    input  logic          hp_wr,
    input  logic [AW-1:0] hp_addr,
    input  logic [DW-1:0] hp_wdata,
    output logic          hm_rd,
    output logic          hm_wr,
    output logic [AW-1:0] hm_addr,
    output logic [DW-1:0] hm_wdata,
    input  logic [DW-1:0] hm_rdata,
    output logic          hp_rvalid,
    output logic [DW-1:0] hp_rdata,
    output logic          hp_viol
);
    origin_t cur_org;

    saf_mode_ctl u_mode (
        .clk(clk), .rst_n(rst_n), .sec_en(sec_en), .ext_mode_pin(ext_mode_pin),
        .mode_wr(mode_wr), .mode_wdata(mode_wdata), .emu_req(emu_req),
        .mode_bit(mode_bit), .emu_en(emu_en)
    );

    saf_origin_reg u_org (
        .clk(clk), .rst_n(rst_n), .ex_adv(ex_adv),
        .ex_origin(origin_t'(ex_origin)), .cur_org(cur_org)
    );

    saf_data_gate #(.AW(AW), .DW(DW), .ROM_LO(ROM_LO), .ROM_HI(ROM_HI), .FILL(FILL)) u_data (
        .clk(clk), .rst_n(rst_n), .sec_en(sec_en), .cur_org(cur_org),
        .dr_req(dr_req), .dr_addr(dr_addr), .dm_rd(dm_rd), .dm_addr(dm_addr),
        .dm_rdata(dm_rdata), .dr_valid(dr_valid), .dr_data(dr_data)
    );

    saf_host_gate #(.AW(AW), .DW(DW), .WIN_LO(WIN_LO), .WIN_HI(WIN_HI), .FILL(FILL)) u_host (
        .clk(clk), .rst_n(rst_n), .sec_en(sec_en), .hp_rd(hp_rd), .hp_wr(hp_wr),
        .hp_addr(hp_addr), .hp_wdata(hp_wdata), .hm_rd(hm_rd), .hm_wr(hm_wr),
        .hm_addr(hm_addr), .hm_wdata(hm_wdata), .hm_rdata(hm_rdata),
        .hp_rvalid(hp_rvalid), .hp_rdata(hp_rdata), .hp_viol(hp_viol)
    );
endmodule

// File: tb/secure_access_filter_test.sv
// Directed bench: one task per scenario, each checking its own results.
module secure_access_filter_test;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0, rst_n = 1'b0, sec_en = 1'b1, ext_mode_pin = 1'b1;
    logic mode_wr = 0, mode_wdata = 0, mode_bit, emu_req = 0, emu_en;
    logic ex_adv = 0;
    logic [1:0] ex_origin = 0;
    logic dr_req = 0, dm_rd, dr_valid;
    logic [15:0] dr_addr = 0, dm_addr, dm_rdata = 0, dr_data;
    logic hp_rd = 0, hp_wr = 0, hm_rd, hm_wr, hp_rvalid, hp_viol;
    logic [15:0] hp_addr = 0, hp_wdata = 0, hm_addr, hm_wdata, hm_rdata = 0, hp_rdata;
    int checks = 0, errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    secure_access_filter uut (.*);

    // Memory models: data one cycle after the strobe.
    always_ff @(posedge clk) begin
        if (dm_rd) dm_rdata <= dm_addr ^ 16'h5A5A;
        if (hm_rd) hm_rdata <= hm_addr ^ 16'h3C3C;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic sec, input logic pin);
        @(negedge clk);
        rst_n = 0; sec_en = sec; ext_mode_pin = pin;
        repeat (2) @(negedge clk);
        rst_n = 1;
    endtask

    task automatic set_origin(input logic [1:0] o);
        @(negedge clk); ex_adv = 1; ex_origin = o;
        @(negedge clk); ex_adv = 0;
    endtask

    // One data read; checks strobe then response.
    task automatic data_read(input string req, input logic [15:0] a, input logic exp_strobe,
                             input logic [15:0] exp_data);
        @(negedge clk); dr_req = 1; dr_addr = a;
        #1 check({req, " strobe"}, dm_rd, exp_strobe);
        @(negedge clk); dr_req = 0;
        check({req, " valid"}, dr_valid, 1);
        check({req, " data"}, dr_data, exp_data);
    endtask

    task automatic host_read(input string req, input logic [15:0] a, input logic exp_strobe,
                             input logic [15:0] exp_data, input logic exp_viol);
        @(negedge clk); hp_rd = 1; hp_addr = a;
        #1 check({req, " strobe"}, hm_rd, exp_strobe);
        @(negedge clk); hp_rd = 0;
        check({req, " rvalid"}, hp_rvalid, 1);
        check({req, " rdata"}, hp_rdata, exp_data);
        check({req, " viol"}, hp_viol, exp_viol);
        @(negedge clk);
        check({req, " viol one cycle"}, hp_viol, 0);
    endtask

    task automatic t_reset;
        do_reset(1, 1);
        @(negedge clk);
        check("R1 mode forced", mode_bit, 0);
        check("R1 dr_valid", dr_valid, 0);
        check("R1 hp_rvalid", hp_rvalid, 0);
        check("R1 hp_viol", hp_viol, 0);
    endtask

    task automatic t_mode;
        @(negedge clk); mode_wr = 1; mode_wdata = 1;
        #1 check("R3 before edge", mode_bit, 0);
        @(negedge clk); mode_wr = 0;
        check("R3 mode written", mode_bit, 1);
        do_reset(0, 1);
        @(negedge clk);
        check("R2 mode from pin", mode_bit, 1);
        do_reset(1, 1);
    endtask

    task automatic t_emu;
        @(negedge clk); emu_req = 1; #1;
        check("R12 emu blocked", emu_en, 0);
        sec_en = 0; #1;
        check("R12 emu follows", emu_en, 1);
        sec_en = 1; emu_req = 0;
    endtask

    task automatic t_rom_secure;
        set_origin(2'd0);
        data_read("R4 rom from rom", 16'hC123, 1, 16'hC123 ^ 16'h5A5A);
        data_read("R4 rom top", 16'hFFFF, 1, 16'hFFFF ^ 16'h5A5A);
        set_origin(2'd1);
        data_read("R5 rom from ram", 16'hC000, 0, 16'hFFFF);
        set_origin(2'd2);
        data_read("R5 rom from ext", 16'hFF10, 0, 16'hFFFF);
        data_read("R6 ram from ext", 16'hBFFF, 1, 16'hBFFF ^ 16'h5A5A);
        set_origin(2'd1);
        data_read("R6 ram from ram", 16'h0100, 1, 16'h0100 ^ 16'h5A5A);
    endtask

    task automatic t_origin_timing;
        set_origin(2'd2);
        @(negedge clk); dr_req = 1; dr_addr = 16'hD000; ex_adv = 1; ex_origin = 2'd0;
        #1 check("R7 same-cycle advance ignored", dm_rd, 0);
        @(negedge clk); dr_req = 0; ex_adv = 0;
        check("R7 fill returned", dr_data, 16'hFFFF);
        data_read("R7 next read uses new tag", 16'hD000, 1, 16'hD000 ^ 16'h5A5A);
    endtask

    task automatic t_host_secure;
        host_read("R9 window low", 16'h4000, 1, 16'h4000 ^ 16'h3C3C, 0);
        host_read("R9 window high", 16'h5FFF, 1, 16'h5FFF ^ 16'h3C3C, 0);
        host_read("R10 below window", 16'h3FFF, 0, 16'hFFFF, 1);
        host_read("R10 above window", 16'h6000, 0, 16'hFFFF, 1);
        @(negedge clk); hp_wr = 1; hp_addr = 16'hC800; hp_wdata = 16'h1234;
        #1 check("R8 write strobe", hm_wr, 1);
        check("R8 write data", hm_wdata, 16'h1234);
        @(negedge clk); hp_wr = 0;
    endtask

    task automatic t_open;
        do_reset(0, 0);
        set_origin(2'd2);
        data_read("R11 rom open", 16'hE000, 1, 16'hE000 ^ 16'h5A5A);
        host_read("R11 host open", 16'h7000, 1, 16'h7000 ^ 16'h3C3C, 0);
        @(negedge clk); hp_wr = 1; hp_addr = 16'h0010;
        #1 check("R8 write open", hm_wr, 1);
        @(negedge clk); hp_wr = 0;
    endtask

    initial begin
        t_reset();
        t_mode();
        t_emu();
        t_rom_secure();
        t_origin_timing();
        t_host_secure();
        t_open();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule